// File: doc/BRIEF.md
# Level-7 Debug Interrupt Gate

This block merges the three top-priority debug interrupt sources into one level-7 request. The sources are a program-breakpoint hit, a bus-breakpoint hit, and an active-low external emulator interrupt pin. Each source has a sticky status bit, so the monitor can tell which source fired. Software clears a status bit by writing 1 to it. The two internal sources can set their bits only while the emulation module is on and their own enable is set. The external pin is synchronised and acts on its falling edge whether or not the module is on.

When hard vectoring is active, the block also presents a fixed vector address (base plus offset, 0xFFFC0010 by default) alongside the request. When hard vectoring is disabled, the vector output reads zero and the vector-valid flag stays low, so the general interrupt controller supplies the vector instead.

Top module: `dbg_l7_gate`

## Requirements
- R1: A program-breakpoint hit sampled while `mod_en` and `prog_en` are both 1 sets status bit 0 after that clock edge.
- R2: A bus-breakpoint hit sampled while `mod_en` and `bus_en` are both 1 sets status bit 1 after that clock edge.
- R3: A falling edge on `ext_irq_n` sets status bit 2 on the third rising clock edge after the pin goes low. This happens whatever the value of `mod_en`. A pin held low, or a rising edge, sets nothing.
- R4: A breakpoint hit is ignored while `mod_en` is 0 or while its own enable is 0. Its status bit stays 0 and `l7_req` stays low.
- R5: `csr_wr` with bit i of `csr_wdata` set to 1 clears status bit i. A 0 in `csr_wdata` leaves that bit unchanged.
- R6: When a clear and a new event for the same source fall in the same cycle, that status bit stays set.
- R7: `l7_req` is high while a status bit is set and its source is permitted. The external bit is always permitted. The internal bits are permitted only with `mod_en` and their own enable, so with `mod_en` at 0 only bit 2 can hold the request.
- R8: With `hv_dis` at 0, `vec_addr` is 0xFFFC0010 and `hard_vec_valid` equals `l7_req`. With `hv_dis` at 1, `vec_addr` is 0 and `hard_vec_valid` is 0.
- R9: After reset, all status bits are 0 and `l7_req` is 0. An idle-high pin at reset release causes no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_bp_hit | input | 1 | Program-breakpoint hit pulse |
| bus_bp_hit | input | 1 | Bus-breakpoint hit pulse |
| ext_irq_n | input | 1 | Asynchronous active-low emulator interrupt pin |
| mod_en | input | 1 | Emulation module enable |
| prog_en | input | 1 | Program-breakpoint interrupt enable |
| bus_en | input | 1 | Bus-breakpoint interrupt enable |
| hv_dis | input | 1 | Hard-vector disable |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 3 | Write-1-to-clear mask: bit 0 program, bit 1 bus, bit 2 external |
| csr_rd_data | output | 3 | Status bits, same layout as `csr_wdata` |
| l7_req | output | 1 | Level-7 interrupt request |
| hard_vec_valid | output | 1 | Request is using the hard-coded vector |
| vec_addr | output | 32 | Hard-coded vector address, or 0 when disabled |

## Verification
The hardest case to reach from the ports is a write-1 clear that lands in the same cycle as a fresh hit on the same source. The stimulus first sets the program bit. It then drives the hit and the clear on the same falling clock edge, so the design samples both at one rising edge. A second hard case is the external pin, because its effect arrives only after the synchroniser. The bench therefore checks the status both one cycle before and exactly at the expected edge. It then holds the pin low after a clear to show that no second event occurs.

// File: rtl/dbg_l7_pkg.sv
package dbg_l7_pkg;
   localparam int SRC_N    = 3;
   localparam int SRC_PROG = 0;
   localparam int SRC_BUS  = 1;
   localparam int SRC_EXT  = 2;
   typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/l7_pin_fall_det.sv
module l7_pin_fall_det #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("l7_pin_fall_det: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[0], pin_n};
         end
      end else begin : g_long
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pin_n};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign fall_o = prev_q & ~chain_q[STAGES-1];

   // R3
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/l7_sticky_bits.sv
module l7_sticky_bits #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("l7_sticky_bits: N must be at least 1");
      end
   endgenerate

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_q <= 1'b0;
            else if (set_i[i]) bit_q <= 1'b1;
            else if (clr_i[i]) bit_q <= 1'b0;
         end
         assign stat_o[i] = bit_q;

         // R6
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> stat_o[i]);
         // R5
         w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !stat_o[i]);
         // R5
         hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !set_i[i]) |=> stat_o[i] == $past(stat_o[i]));
      end
   endgenerate
endmodule

// File: rtl/dbg_l7_gate.sv
module dbg_l7_gate
   import dbg_l7_pkg::*;
#(
   parameter int unsigned           ADDR_W      = 32,
   parameter logic [ADDR_W-1:0]     VEC_BASE    = 'hFFFC0000,
   parameter logic [ADDR_W-1:0]     VEC_OFS     = 'h10,
   parameter int unsigned           SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_bp_hit,
   input  logic              bus_bp_hit,
   input  logic              ext_irq_n,
   input  logic              mod_en,
   input  logic              prog_en,
   input  logic              bus_en,
   input  logic              hv_dis,
   input  logic              csr_wr,
   input  logic [SRC_N-1:0]  csr_wdata,
   output logic [SRC_N-1:0]  csr_rd_data,
   output logic              l7_req,
   output logic              hard_vec_valid,
   output logic [ADDR_W-1:0] vec_addr
);
   localparam logic [ADDR_W-1:0] HARD_VEC = VEC_BASE + VEC_OFS;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("dbg_l7_gate: ADDR_W too small");
      end
   endgenerate

   logic     ext_fall;
   src_vec_t permit, set_v, clr_v, stat;

   l7_pin_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (ext_irq_n),
      .fall_o (ext_fall)
   );

   always_comb begin
      permit           = '0;
      permit[SRC_PROG] = mod_en & prog_en;
      permit[SRC_BUS]  = mod_en & bus_en;
      permit[SRC_EXT]  = 1'b1;
      set_v            = '0;
      set_v[SRC_PROG]  = prog_bp_hit;
      set_v[SRC_BUS]   = bus_bp_hit;
      set_v[SRC_EXT]   = ext_fall;
      set_v            = set_v & permit;
      clr_v            = csr_wr ? csr_wdata : '0;
   end

   l7_sticky_bits #(.N(SRC_N)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .stat_o (stat)
   );

   assign csr_rd_data    = stat;
   assign l7_req         = |(stat & permit);
   assign hard_vec_valid = l7_req & ~hv_dis;
   assign vec_addr       = hv_dis ? '0 : HARD_VEC;

   // R7
   disabled_ext_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mod_en && l7_req) |-> csr_rd_data[SRC_EXT]);
   // R4
   disabled_no_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mod_en && !csr_rd_data[SRC_PROG]) |=> !csr_rd_data[SRC_PROG]);
   // R4
   disabled_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mod_en && !csr_rd_data[SRC_BUS]) |=> !csr_rd_data[SRC_BUS]);
   // R8
   hard_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hard_vec_valid |-> (vec_addr == HARD_VEC && l7_req));
   // R7
   req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l7_req |-> (csr_rd_data != '0));
endmodule

// File: tb/dbg_l7_gate_tb.sv
module dbg_l7_gate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_bp_hit = 1'b0, bus_bp_hit = 1'b0, ext_irq_n = 1'b1;
   logic        mod_en = 1'b0, prog_en = 1'b0, bus_en = 1'b0, hv_dis = 1'b0;
   logic        csr_wr = 1'b0;
   logic [2:0]  csr_wdata = '0;
   logic [2:0]  csr_rd_data;
   logic        l7_req, hard_vec_valid;
   logic [31:0] vec_addr;
   int          n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   dbg_l7_gate u_dut (
      .clk(clk), .rst_n(rst_n), .prog_bp_hit(prog_bp_hit), .bus_bp_hit(bus_bp_hit),
      .ext_irq_n(ext_irq_n), .mod_en(mod_en), .prog_en(prog_en), .bus_en(bus_en),
      .hv_dis(hv_dis), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
      .csr_rd_data(csr_rd_data), .l7_req(l7_req),
      .hard_vec_valid(hard_vec_valid), .vec_addr(vec_addr)
   );

   // entry: {prog, bus, mod_en, prog_en, bus_en, exp_bus_bit, exp_prog_bit, exp_req}
   localparam logic [7:0] VECS [8] = '{
      8'b1_0_111_011, 8'b0_1_111_101, 8'b1_1_111_111, 8'b1_1_110_011,
      8'b1_1_101_101, 8'b1_1_011_000, 8'b1_0_101_000, 8'b0_0_111_000
   };

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk); csr_wr = 1'b1; csr_wdata = 3'b111;
      @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL R9 watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 status", {29'b0, csr_rd_data}, 0);
      chk("R9 req", {31'b0, l7_req}, 0);

      // table walk: R1 R2 R4
      foreach (VECS[k]) begin
         @(negedge clk);
         {prog_bp_hit, bus_bp_hit, mod_en, prog_en, bus_en} = VECS[k][7:3];
         @(negedge clk);
         prog_bp_hit = 1'b0; bus_bp_hit = 1'b0;
         chk("R1/R2/R4 status", {30'b0, csr_rd_data[1:0]}, {30'b0, VECS[k][2:1]});
         chk("R7 req", {31'b0, l7_req}, {31'b0, VECS[k][0]});
         clear_all();
         chk("R5 cleared", {29'b0, csr_rd_data}, 0);
      end

      // R8 hard vector
      mod_en = 1'b1; prog_en = 1'b1; bus_en = 1'b1; hv_dis = 1'b0;
      @(negedge clk); prog_bp_hit = 1'b1;
      @(negedge clk); prog_bp_hit = 1'b0;
      chk("R8 vec", vec_addr, 32'hFFFC0010);
      chk("R8 valid", {31'b0, hard_vec_valid}, 1);
      hv_dis = 1'b1;
      @(negedge clk);
      chk("R8 disabled vec", vec_addr, 0);
      chk("R8 disabled valid", {31'b0, hard_vec_valid}, 0);
      hv_dis = 1'b0;

      // R5 write 0 leaves bit
      csr_wr = 1'b1; csr_wdata = 3'b110;
      @(negedge clk); csr_wr = 1'b0; csr_wdata = '0;
      chk("R5 zero write keeps", {29'b0, csr_rd_data}, 1);

      // R6 clear and set in same cycle
      prog_bp_hit = 1'b1; csr_wr = 1'b1; csr_wdata = 3'b001;
      @(negedge clk); prog_bp_hit = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
      chk("R6 set wins", {29'b0, csr_rd_data}, 1);
      clear_all();

      // R3 external pin latency
      mod_en = 1'b0;
      ext_irq_n = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R3 not yet", {29'b0, csr_rd_data}, 0);
      @(negedge clk);
      chk("R3 ext set", {29'b0, csr_rd_data}, 3'b100);
      chk("R7 ext req while disabled", {31'b0, l7_req}, 1);
      clear_all();
      repeat (4) @(negedge clk);
      chk("R3 held low no retrigger", {29'b0, csr_rd_data}, 0);
      ext_irq_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R3 rising no event", {29'b0, csr_rd_data}, 0);

      // R7 disabled module masks internal bit
      mod_en = 1'b1;
      @(negedge clk); prog_bp_hit = 1'b1;
      @(negedge clk); prog_bp_hit = 1'b0;
      mod_en = 1'b0;
      @(negedge clk);
      chk("R7 internal masked", {31'b0, l7_req}, 0);
      chk("R7 bit kept", {29'b0, csr_rd_data}, 1);
      @(negedge clk); bus_bp_hit = 1'b1;
      @(negedge clk); bus_bp_hit = 1'b0;
      chk("R4 bus ignored disabled", {29'b0, csr_rd_data}, 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule